// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block watches the byte stream on a NAND data port and builds, one byte at a time, the parity terms of a single-error-correcting Hamming code over a 256-byte chunk. Every byte that crosses the port is presented on `data_i` together with a one-cycle strobe. From each byte the block forms two kinds of parity. Line parity is a pair of bits for each bit of the byte's position within the chunk, 16 bits in all. Column parity is a pair of bits for each bit of the bit index within a byte, 6 bits in all. An 8-bit counter tracks how many bytes have been strobed.

A host reads the accumulated values through a small byte-wide register port with word-spaced offsets. It restarts the accumulator by writing to a dedicated clear offset. Software turns the raw values into a 3-byte code:
- code byte 0 is the complement of line bits 15..8;
- code byte 1 is the complement of line bits 7..0;
- code byte 2 is the complemented column parity shifted left by two, with its two low bits set.

The host takes a nonzero counter after a chunk as a short transfer. Comparing stored and recomputed codes is done elsewhere.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, every readable register (offsets 0x00, 0x04, 0x08, 0x0C) reads 0.
- R2: The byte counter at offset 0x0C increases by one on each clock with `stb_i` high and no clear, wraps from 255 to 0, and so reads 0 after exactly 256 strobed bytes and 1 after 257.
- R3: For position bit k (0..7) of the byte's position p in the chunk (p = counter value when the byte is strobed), line bit 2k accumulates the XOR of all data bits of bytes with p[k]=0 and line bit 2k+1 does the same for bytes with p[k]=1.
- R4: For index bit j (0..2) of a data bit's index i within the byte, column bit 2j accumulates the XOR of the data bits with i[j]=0 over all strobed bytes, and column bit 2j+1 does the same for i[j]=1.
- R5: Reads are combinational: offset 0x00 returns line bits 7..0, 0x04 returns line bits 15..8, 0x08 returns column bits 5..0 in bits 5..0 with bits 7..6 zero, and 0x0C returns the counter.
- R6: A write (`wr_i` high) to offset 0x10 sets all line bits, column bits and the counter to zero on the next edge, whatever `wdata_i` holds.
- R7: When a clear write and a byte strobe fall in the same cycle, the clear wins: every register reads 0 afterwards and the byte is not counted.
- R8: With no strobe and no clear the state holds. Writes to any offset other than 0x10 have no effect.
- R9: Reads of any offset other than the four in R5, including the clear offset 0x10, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte crossing the flash data port |
| stb_i | input | 1 | Byte valid, one per transferred byte |
| wr_i | input | 1 | Register write enable |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 8 | Register write data (ignored) |
| rdata_o | output | 8 | Register read data, combinational on `addr_i` |

## Verification
The assertions take for granted that `stb_i`, `wr_i` and `addr_i` carry known values at every rising edge after reset. They also take for granted that a byte's position is the counter value at its strobe, so a chunk must start right after a clear. The stimulus drives every input on the falling edge and always issues a clear before a new sweep. The one exception is the wrap test, where the stream deliberately runs past 256 bytes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int unsigned WORD_SHIFT = 2;

  function automatic int unsigned words_for(input int unsigned bits, input int unsigned word_w);
    return (bits + word_w - 1) / word_w;
  endfunction

  function automatic int unsigned word_offset(input int unsigned idx);
    return idx << WORD_SHIFT;
  endfunction

endpackage

// File: rtl/ecc_byte_cnt.sv
module ecc_byte_cnt #(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  output logic [POS_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (stb_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ecc_line_par.sv
module ecc_line_par #(
  parameter int unsigned POS_W = 8,
  localparam int unsigned LP_W = 2 * POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             byte_par_i,
  output logic [LP_W-1:0]  par_o
);
  for (genvar k = 0; k < POS_W; k++) begin : g_pair
    logic even_q, odd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        even_q <= 1'b0;
        odd_q  <= 1'b0;
      end else if (clr_i) begin
        even_q <= 1'b0;
        odd_q  <= 1'b0;
      end else if (stb_i) begin
        if (pos_i[k]) odd_q  <= odd_q ^ byte_par_i;
        else          even_q <= even_q ^ byte_par_i;
      end
    end
    assign par_o[2*k]   = even_q;
    assign par_o[2*k+1] = odd_q;
  end
endmodule

// File: rtl/ecc_col_par.sv
module ecc_col_par #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W),
  localparam int unsigned CP_W  = 2 * SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CP_W-1:0]   par_o
);
  for (genvar j = 0; j < SEL_W; j++) begin : g_pair
    logic lo_t, hi_t;
    logic lo_q, hi_q;
    always_comb begin
      lo_t = 1'b0;
      hi_t = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (((i >> j) & 1) == 1) hi_t = hi_t ^ data_i[i];
        else                     lo_t = lo_t ^ data_i[i];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= 1'b0;
        hi_q <= 1'b0;
      end else if (clr_i) begin
        lo_q <= 1'b0;
        hi_q <= 1'b0;
      end else if (stb_i) begin
        lo_q <= lo_q ^ lo_t;
        hi_q <= hi_q ^ hi_t;
      end
    end
    assign par_o[2*j]   = lo_q;
    assign par_o[2*j+1] = hi_q;
  end
endmodule

// File: rtl/ecc_reg_rd.sv
module ecc_reg_rd
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 8,
  parameter int unsigned CP_W   = 6,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned LP_W     = 2 * POS_W,
  localparam int unsigned LP_WORDS = words_for(LP_W, DATA_W),
  localparam int unsigned IDX_W    = ADDR_W - WORD_SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LP_W-1:0]   lp_i,
  input  logic [CP_W-1:0]   cp_i,
  input  logic [POS_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LP_WORDS*DATA_W-1:0] lp_pad;
  logic [DATA_W-1:0]          cp_pad, cnt_pad;
  logic [IDX_W-1:0]           idx;
  logic                       aligned;

  assign idx     = addr_i[ADDR_W-1:WORD_SHIFT];
  assign aligned = (addr_i[WORD_SHIFT-1:0] == '0);

  always_comb begin
    lp_pad = '0;
    lp_pad[LP_W-1:0] = lp_i;
    cp_pad = '0;
    cp_pad[CP_W-1:0] = cp_i;
    cnt_pad = '0;
    cnt_pad[POS_W-1:0] = cnt_i;
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      for (int w = 0; w < LP_WORDS; w++)
        if (idx == IDX_W'(w)) rdata_o = lp_pad[w*DATA_W +: DATA_W];
      if (idx == IDX_W'(LP_WORDS))     rdata_o = cp_pad;
      if (idx == IDX_W'(LP_WORDS + 1)) rdata_o = cnt_pad;
    end
  end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 8,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned LP_W     = 2 * POS_W,
  localparam int unsigned CP_W     = 2 * $clog2(DATA_W),
  localparam int unsigned LP_WORDS = words_for(LP_W, DATA_W),
  localparam int unsigned CLR_ADDR = word_offset(LP_WORDS + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stb_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic             clr;
  logic             byte_par;
  logic [LP_W-1:0]  line_par;
  logic [CP_W-1:0]  col_par;
  logic [POS_W-1:0] byte_cnt;
  logic             unused_wdata;

  assign clr          = wr_i && (addr_i == ADDR_W'(CLR_ADDR));
  assign byte_par     = ^data_i;
  assign unused_wdata = ^wdata_i;

  ecc_byte_cnt #(.POS_W(POS_W)) cnt_u (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .stb_i(stb_i), .cnt_o(byte_cnt)
  );

  ecc_line_par #(.POS_W(POS_W)) line_u (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .stb_i(stb_i),
    .pos_i(byte_cnt), .byte_par_i(byte_par), .par_o(line_par)
  );

  ecc_col_par #(.DATA_W(DATA_W)) col_u (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .stb_i(stb_i),
    .data_i(data_i), .par_o(col_par)
  );

  ecc_reg_rd #(.DATA_W(DATA_W), .POS_W(POS_W), .CP_W(CP_W), .ADDR_W(ADDR_W)) rd_u (
    .addr_i(addr_i), .lp_i(line_par), .cp_i(col_par), .cnt_i(byte_cnt), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/nand_ecc_acc_chk.sv
module nand_ecc_acc_chk #(
  parameter int unsigned POS_W    = 8,
  parameter int unsigned CP_W     = 6,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CLR_ADDR = 16,
  localparam int unsigned LP_W = 2 * POS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stb_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [LP_W-1:0]   lp_i,
  input logic [CP_W-1:0]   cp_i,
  input logic [POS_W-1:0]  cnt_i
);
  logic clr_seen;
  assign clr_seen = wr_i && (addr_i == ADDR_W'(CLR_ADDR));

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_seen |=> (lp_i == '0 && cp_i == '0 && cnt_i == '0));

  // R7
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_seen && stb_i) |=> (cnt_i == '0));

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !clr_seen) |=> (cnt_i == $past(cnt_i) + 1'b1));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i && !clr_seen) |=> ($stable(lp_i) && $stable(cp_i) && $stable(cnt_i)));

  // R3
  line_pairs_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^lp_i[1:0]) == (^lp_i[LP_W-1:LP_W-2]));

  // R4
  col_line_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^cp_i[1:0]) == (^lp_i[1:0]));
endmodule

bind nand_ecc_acc nand_ecc_acc_chk #(
  .POS_W(POS_W), .CP_W(CP_W), .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb_i), .wr_i(wr_i), .addr_i(addr_i),
  .lp_i(line_par), .cp_i(col_par), .cnt_i(byte_cnt)
);

// File: tb/nand_ecc_acc_tb_top.sv
module nand_ecc_acc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       stb_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] m_lp;
  logic [5:0]  m_cp;
  logic [7:0]  m_cnt;

  always #10 clk_i = ~clk_i;

  nand_ecc_acc dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .stb_i(stb_i),
    .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic put_byte(input logic [7:0] d);
    logic bp;
    bp = ^d;
    data_i = d;
    stb_i = 1'b1;
    for (int k = 0; k < 8; k++)
      if (m_cnt[k]) m_lp[2*k+1] ^= bp; else m_lp[2*k] ^= bp;
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++)
        if (((i >> j) & 1) == 1) m_cp[2*j+1] ^= d[i]; else m_cp[2*j] ^= d[i];
    m_cnt = m_cnt + 8'd1;
    @(negedge clk_i);
    stb_i = 1'b0;
  endtask

  task automatic clear(input logic [7:0] wd);
    wr_i = 1'b1;
    addr_i = 5'h10;
    wdata_i = wd;
    @(negedge clk_i);
    wr_i = 1'b0;
    m_lp = '0;
    m_cp = '0;
    m_cnt = '0;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    rd(5'h00, v); check({tag, " line lo"}, v, m_lp[7:0]);
    rd(5'h04, v); check({tag, " line hi"}, v, m_lp[15:8]);
    rd(5'h08, v); check({tag, " col"}, v, {2'b00, m_cp});
    rd(5'h0C, v); check({tag, " cnt"}, v, m_cnt);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] e_lp;
    logic [5:0] e_cp;
    m_lp = '0; m_cp = '0; m_cnt = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 reset");

    // R3 R4 R5: single set bit at sampled positions, expected computed arithmetically
    for (int b = 0; b < 256; b += 17) begin
      for (int i = 0; i < 8; i++) begin
        clear(8'h00);
        for (int z = 0; z < b; z++) put_byte(8'h00);
        put_byte(8'(1 << i));
        e_lp = '0;
        for (int k = 0; k < 8; k++) e_lp[2*k + ((b >> k) & 1)] = 1'b1;
        e_cp = '0;
        for (int j = 0; j < 3; j++) e_cp[2*j + ((i >> j) & 1)] = 1'b1;
        rd(5'h00, v); check("R3 R5 line lo single", v, e_lp[7:0]);
        rd(5'h04, v); check("R3 R5 line hi single", v, e_lp[15:8]);
        rd(5'h08, v); check("R4 R5 col single", v, {2'b00, e_cp});
        rd(5'h0C, v); check("R2 cnt single", v, 8'(b + 1));
      end
    end

    // R2 R3 R4: full chunks with several patterns
    for (int p = 0; p < 4; p++) begin
      clear(8'h00);
      for (int n = 0; n < 256; n++) begin
        case (p)
          0: put_byte(8'(n));
          1: put_byte(~8'(n));
          2: put_byte(8'(n * 37 + 5));
          default: put_byte(8'hFF);
        endcase
      end
      check_all("R2 R3 R4 chunk");
      rd(5'h0C, v); check("R2 cnt zero after 256", v, 8'h00);
    end

    // R2 wrap: one byte past a chunk
    put_byte(8'h5A);
    rd(5'h0C, v); check("R2 cnt after 257", v, 8'h01);

    // R6 clear regardless of data
    for (int n = 0; n < 20; n++) put_byte(8'(n * 11 + 3));
    clear(8'hA5);
    rd(5'h00, v); check("R6 line lo clr", v, 8'h00);
    rd(5'h04, v); check("R6 line hi clr", v, 8'h00);
    rd(5'h08, v); check("R6 col clr", v, 8'h00);
    rd(5'h0C, v); check("R6 cnt clr", v, 8'h00);

    // R7 clear and strobe in the same cycle
    for (int n = 0; n < 9; n++) put_byte(8'(n + 1));
    data_i = 8'h01;
    stb_i = 1'b1;
    clear(8'h3C);
    stb_i = 1'b0;
    rd(5'h00, v); check("R7 line lo", v, 8'h00);
    rd(5'h04, v); check("R7 line hi", v, 8'h00);
    rd(5'h08, v); check("R7 col", v, 8'h00);
    rd(5'h0C, v); check("R7 cnt", v, 8'h00);

    // R8 idle cycles and writes to other offsets change nothing
    for (int n = 0; n < 13; n++) put_byte(8'(n * 29 + 7));
    data_i = 8'hFF;
    repeat (5) @(negedge clk_i);
    for (int a = 0; a < 32; a++) begin
      if (a != 16) begin
        wr_i = 1'b1;
        addr_i = 5'(a);
        wdata_i = 8'hFF;
        @(negedge clk_i);
        wr_i = 1'b0;
      end
    end
    check_all("R8 hold");

    // R9 unmapped offsets read zero
    for (int a = 0; a < 32; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12) begin
        rd(5'(a), v);
        check("R9 unmapped", v, 8'h00);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule